// File: doc/BRIEF.md
# Configurable Nearest-Neighbour Cell Mesh with Serial Configuration Loader

The block is a two-dimensional grid of small configurable logic cells. Each cell talks only to the cells directly above, below, left and right of it. A cell holds a private configuration word. That word picks three input sources from its four neighbours. It also sets the logic function applied to those inputs, either a two-input truth table or a three-input multiplexer. Finally, it decides for each of the four faces whether that face carries the function result or passes through a signal arriving at another face. Every face output is registered, so each hop across a cell costs one clock.

A host loads the whole grid through a one-bit serial port. The bits form one long string. The first bits belong to the bottom-left cell, and the cells follow left to right, then row by row upward. Inside each cell the least significant bit comes first. The string fills a shadow store and is copied into the live configuration in a single step when the final bit arrives. A one-cycle done pulse marks that copy. Every bit pattern is legal, so the loader has no checking logic. While a load is under way, the primary output reads 0.

The mesh has one primary input, which enters the west side of a chosen row. It has one primary output, taken from the east side of another chosen row. Every other edge input sees a fixed constant.

Top module: `mesh_fabric`

## Requirements
- R1: After reset every configuration bit is 0. This makes every cell compute constant 0 on all four faces. `priOut` and `cfgDone` are 0 and stay 0 whatever `priIn` does, until a configuration is loaded.
- R2: A bit is accepted on each rising edge where `cfgValid` is 1. Accepted bit k (counting from 0 since the last completed load) becomes bit k mod 19 of cell k div 19. Cell index is row*COLS + column, where row 0 is the bottom row and column 0 is the west column.
- R3: `cfgDone` is 1 for exactly one cycle: the cycle after the edge that accepted bit ROWS*COLS*19-1. The live configuration changes at that same edge and at no other time.
- R4: From the cycle after the first accepted bit of a load, up to and including the cycle before `cfgDone`, `priOut` is 0. Meanwhile the cells keep running the previous configuration.
- R5: Cell word fields are as follows. Bits 3:0 are a truth table indexed by {X2,X1}. Bit 4 set selects multiplexer mode, F = X3 ? X2 : X1. Bits 6:5, 8:7 and 10:9 pick the source of X1, X2 and X3, coded 0 north, 1 east, 2 south, 3 west.
- R6: Bits 12:11, 14:13, 16:15 and 18:17 select the north, east, south and west face outputs. Call the face's direction code d. Value 0 drives F. Value s drives the signal arriving at the face with code (d+s) mod 4.
- R7: Every face output is a register, reset to 0, that loads its selected value on every clock edge.
- R8: A cell's north input is the south face of the cell above it, and its east input is the west face of the cell to its right. The south and west inputs follow the same pattern from the cells below and to the left.
- R9: `priIn` feeds the west input of cell (IN_ROW, 0). `priOut` is the east face of cell (OUT_ROW, COLS-1). Every other edge input equals EDGE_VAL (0 by default).
- R10: Any configuration string, including fully random ones, is accepted and produces the behaviour above with no error indication.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgValid | input | 1 | Serial configuration bit is valid this cycle |
| cfgBit | input | 1 | Serial configuration data bit |
| cfgDone | output | 1 | One-cycle pulse when the new configuration goes live |
| priIn | input | 1 | Primary input pad into the mesh edge |
| priOut | output | 1 | Primary output pad from the mesh edge |

## Verification
The assertions assume that `cfgValid` stays low while reset is applied. The output-hold property looks back one cycle at `cfgValid` and needs a loader that began counting after reset. They also assume that no load is abandoned part way, so the done pulse always follows a full string of accepted bits. The stimulus keeps valid low during reset and always completes every load it starts. It inserts random idle gaps between bits and changes the primary input at random in every cycle, including mid-load. A bench model of the registered mesh, stepped in lockstep, supplies the expected output in every cycle.

// File: rtl/mesh_pkg.sv
package mesh_pkg;

  localparam int CELL_CFG_W = 19;

  localparam int DIR_N = 0;
  localparam int DIR_E = 1;
  localparam int DIR_S = 2;
  localparam int DIR_W = 3;

  localparam int LUT_LSB      = 0;
  localparam int MODE_BIT     = 4;
  localparam int SEL_X1_LSB   = 5;
  localparam int SEL_X2_LSB   = 7;
  localparam int SEL_X3_LSB   = 9;
  localparam int FACE_SEL_LSB = 11;

  typedef struct packed {
    logic shiftEn;
    logic commit;
    logic holdOut;
  } cfgStrobe_t;

endpackage

// File: rtl/mesh_cell.sv
module mesh_cell
  import mesh_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CELL_CFG_W-1:0] cfg,
  input  logic [3:0]            inFace,
  output logic [3:0]            outFace
);

  logic       x1, x2, x3, fVal;
  logic [3:0] lut;
  logic [1:0] lutIdx;
  logic [3:0] nxtFace;

  assign x1     = inFace[cfg[SEL_X1_LSB +: 2]];
  assign x2     = inFace[cfg[SEL_X2_LSB +: 2]];
  assign x3     = inFace[cfg[SEL_X3_LSB +: 2]];
  assign lut    = cfg[LUT_LSB +: 4];
  assign lutIdx = {x2, x1};
  assign fVal   = cfg[MODE_BIT] ? (x3 ? x2 : x1) : lut[lutIdx];

  for (genvar d = 0; d < 4; d++) begin : g_face
    logic [1:0] sel;
    logic [1:0] srcIdx;
    assign sel    = cfg[FACE_SEL_LSB + 2*d +: 2];
    assign srcIdx = 2'(d) + sel;
    assign nxtFace[d] = (sel == 2'd0) ? fVal : inFace[srcIdx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) outFace <= '0;
    else        outFace <= nxtFace;
  end

endmodule

// File: rtl/mesh_cfg_ctrl.sv
module mesh_cfg_ctrl
  import mesh_pkg::*;
#(
  parameter int TOTAL_BITS = 1900
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfgValid,
  output cfgStrobe_t strobe,
  output logic       cfgDone
);

  localparam int CNT_W = $clog2(TOTAL_BITS);

  logic [CNT_W-1:0] bitCount;
  logic             busy;
  logic             lastBit;

  assign lastBit = (bitCount == CNT_W'(TOTAL_BITS - 1));

  always_comb begin
    strobe.shiftEn = cfgValid;
    strobe.commit  = cfgValid && lastBit;
    strobe.holdOut = busy;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bitCount <= '0;
      busy     <= 1'b0;
      cfgDone  <= 1'b0;
    end else begin
      cfgDone <= strobe.commit;
      if (strobe.commit) begin
        bitCount <= '0;
        busy     <= 1'b0;
      end else if (cfgValid) begin
        bitCount <= bitCount + 1'b1;
        busy     <= 1'b1;
      end
    end
  end

  // R2: the bit position never runs past the end of the string
  a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    bitCount <= CNT_W'(TOTAL_BITS - 1));

  // R3: the done indication lasts a single cycle
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    cfgDone |=> !cfgDone);

endmodule

// File: rtl/mesh_datapath.sv
module mesh_datapath
  import mesh_pkg::*;
#(
  parameter int   COLS     = 10,
  parameter int   ROWS     = 10,
  parameter int   IN_ROW   = 2,
  parameter int   OUT_ROW  = 7,
  parameter logic EDGE_VAL = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  cfgStrobe_t strobe,
  input  logic       cfgBit,
  input  logic       priIn,
  output logic       priOut
);

  localparam int NCELL      = COLS * ROWS;
  localparam int TOTAL_BITS = NCELL * CELL_CFG_W;
  localparam int OUT_IDX    = OUT_ROW * COLS + COLS - 1;

  logic [TOTAL_BITS-1:0] shadow;
  logic [TOTAL_BITS-1:0] shadowNext;
  logic [TOTAL_BITS-1:0] activeFlat;

  assign shadowNext = {cfgBit, shadow[TOTAL_BITS-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow     <= '0;
      activeFlat <= '0;
    end else begin
      if (strobe.shiftEn) shadow     <= shadowNext;
      if (strobe.commit)  activeFlat <= shadowNext;
    end
  end

  logic [3:0] face [NCELL];
  logic       inN  [NCELL];
  logic       inE  [NCELL];
  logic       inS  [NCELL];
  logic       inW  [NCELL];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int IDX = r * COLS + c;

      if (r == ROWS - 1) begin : g_nEdge
        assign inN[IDX] = EDGE_VAL;
      end else begin : g_nLink
        assign inN[IDX] = face[IDX + COLS][DIR_S];
      end

      if (c == COLS - 1) begin : g_eEdge
        assign inE[IDX] = EDGE_VAL;
      end else begin : g_eLink
        assign inE[IDX] = face[IDX + 1][DIR_W];
      end

      if (r == 0) begin : g_sEdge
        assign inS[IDX] = EDGE_VAL;
      end else begin : g_sLink
        assign inS[IDX] = face[IDX - COLS][DIR_N];
      end

      if (c == 0) begin : g_wEdge
        if (r == IN_ROW) begin : g_pad
          assign inW[IDX] = priIn;
        end else begin : g_const
          assign inW[IDX] = EDGE_VAL;
        end
      end else begin : g_wLink
        assign inW[IDX] = face[IDX - 1][DIR_E];
      end

      mesh_cell u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (activeFlat[IDX*CELL_CFG_W +: CELL_CFG_W]),
        .inFace  ({inW[IDX], inS[IDX], inE[IDX], inN[IDX]}),
        .outFace (face[IDX])
      );
    end
  end

  assign priOut = strobe.holdOut ? 1'b0 : face[OUT_IDX][DIR_E];

  // R3: the live configuration changes only at the commit edge
  a_r3_live_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.commit |=> $stable(activeFlat));

endmodule

// File: rtl/mesh_fabric.sv
module mesh_fabric
  import mesh_pkg::*;
#(
  parameter int   COLS     = 10,
  parameter int   ROWS     = 10,
  parameter int   IN_ROW   = 2,
  parameter int   OUT_ROW  = 7,
  parameter logic EDGE_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfgValid,
  input  logic cfgBit,
  output logic cfgDone,
  input  logic priIn,
  output logic priOut
);

  localparam int TOTAL_BITS = COLS * ROWS * CELL_CFG_W;

  cfgStrobe_t strobe;

  mesh_cfg_ctrl #(.TOTAL_BITS(TOTAL_BITS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfgValid (cfgValid),
    .strobe   (strobe),
    .cfgDone  (cfgDone)
  );

  mesh_datapath #(
    .COLS(COLS), .ROWS(ROWS), .IN_ROW(IN_ROW), .OUT_ROW(OUT_ROW), .EDGE_VAL(EDGE_VAL)
  ) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .cfgBit (cfgBit),
    .priIn  (priIn),
    .priOut (priOut)
  );

  // R3: a done pulse always follows an accepted bit
  a_r3_done_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
    cfgDone |-> $past(cfgValid));

  // R4: after a non-final accepted bit the output reads 0
  a_r4_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cfgValid) && !cfgDone) |-> (priOut == 1'b0));

endmodule

// File: tb/sim_mesh_fabric.sv
module sim_mesh_fabric;

  localparam int COLS    = 10;
  localparam int ROWS    = 10;
  localparam int IN_ROW  = 2;
  localparam int OUT_ROW = 7;
  localparam int CW      = 19;
  localparam int NCELL   = COLS * ROWS;
  localparam int TOTAL   = NCELL * CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfgValid = 1'b0;
  logic cfgBit = 1'b0;
  logic priIn = 1'b0;
  logic cfgDone, priOut;

  always #5 clk = ~clk;

  mesh_fabric u0 (
    .clk(clk), .rst_n(rst_n), .cfgValid(cfgValid), .cfgBit(cfgBit),
    .cfgDone(cfgDone), .priIn(priIn), .priOut(priOut)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  string curTag = "R1";

  logic [CW-1:0] mCfg   [NCELL];
  logic [CW-1:0] newCfg [NCELL];
  logic          mSt    [ROWS][COLS][4];
  logic          mNx    [ROWS][COLS][4];
  int            bitIdx  = 0;
  logic          expBusy = 1'b0;
  logic          expDone = 1'b0;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic edgeIn(int r, int c, int d, logic pin);
    case (d)
      0: return (r == ROWS-1) ? 1'b0 : mSt[r+1][c][2];
      1: return (c == COLS-1) ? 1'b0 : mSt[r][c+1][3];
      2: return (r == 0) ? 1'b0 : mSt[r-1][c][0];
      default: return (c == 0) ? ((r == IN_ROW) ? pin : 1'b0) : mSt[r][c-1][1];
    endcase
  endfunction

  task automatic modelStep(input logic pin);
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        logic [CW-1:0] w;
        logic [3:0] iv;
        logic a, b, s, f;
        w = mCfg[r*COLS + c];
        for (int d = 0; d < 4; d++) iv[d] = edgeIn(r, c, d, pin);
        a = iv[w[6:5]];
        b = iv[w[8:7]];
        s = iv[w[10:9]];
        f = w[4] ? (s ? b : a) : w[{b, a}];
        for (int d = 0; d < 4; d++) begin
          int sel;
          sel = int'(w[11 + 2*d +: 2]);
          mNx[r][c][d] = (sel == 0) ? f : iv[(d + sel) % 4];
        end
      end
    end
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        for (int d = 0; d < 4; d++) mSt[r][c][d] = mNx[r][c][d];
  endtask

  task automatic tick(input logic v, input logic b);
    logic pin, last;
    @(negedge clk);
    chk("R3", cfgDone, expDone);
    chk(expBusy ? "R4" : curTag, priOut, expBusy ? 1'b0 : mSt[OUT_ROW][COLS-1][1]);
    pin = 1'($urandom);
    priIn = pin;
    cfgValid = v;
    cfgBit = b;
    last = v && (bitIdx == TOTAL - 1);
    modelStep(pin);
    expDone = last;
    if (last) begin
      for (int i = 0; i < NCELL; i++) mCfg[i] = newCfg[i];
      bitIdx = 0;
      expBusy = 1'b0;
    end else if (v) begin
      bitIdx++;
      expBusy = 1'b1;
    end
  endtask

  task automatic loadNew();
    for (int i = 0; i < NCELL; i++)
      for (int j = 0; j < CW; j++) begin
        if ($urandom % 8 == 0) tick(1'b0, 1'b0);
        tick(1'b1, newCfg[i][j]);
      end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) tick(1'b0, 1'b0);
  endtask

  function automatic int cix(int r, int c);
    return r * COLS + c;
  endfunction

  task automatic clearNew();
    for (int i = 0; i < NCELL; i++) newCfg[i] = '0;
  endtask

  task automatic buildWire();
    clearNew();
    for (int c = 0; c < COLS - 1; c++) newCfg[cix(IN_ROW, c)][14:13] = 2'd2;
    newCfg[cix(IN_ROW, COLS-1)][12:11] = 2'd3;
    for (int r = IN_ROW + 1; r < OUT_ROW; r++) newCfg[cix(r, COLS-1)][12:11] = 2'd2;
    newCfg[cix(OUT_ROW, COLS-1)][14:13] = 2'd1;
  endtask

  initial begin
    void'($urandom(32'd5150));
    for (int i = 0; i < NCELL; i++) begin
      mCfg[i] = '0;
      newCfg[i] = '0;
    end
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        for (int d = 0; d < 4; d++) mSt[r][c][d] = 1'b0;

    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: cleared configuration, output stays 0 under random input
    curTag = "R1";
    idle(40);

    // R2: single constant-1 cell at a raster position drives the output
    curTag = "R2";
    clearNew();
    newCfg[cix(OUT_ROW, COLS-1)][3:0] = 4'hF;
    loadNew();
    idle(20);

    // R9 and R7: wire path from input pad to output pad, one cycle per hop
    curTag = "R9";
    buildWire();
    loadNew();
    curTag = "R7";
    idle(80);

    // R5: final cell inverts its south input instead of passing it
    curTag = "R5";
    buildWire();
    newCfg[cix(OUT_ROW, COLS-1)] = '0;
    newCfg[cix(OUT_ROW, COLS-1)][3:0] = 4'b0101;
    newCfg[cix(OUT_ROW, COLS-1)][6:5] = 2'd2;
    loadNew();
    idle(60);

    // R6, R8, R10: fully random configuration strings
    for (int p = 0; p < 3; p++) begin
      curTag = (p == 0) ? "R6" : (p == 1) ? "R8" : "R10";
      for (int i = 0; i < NCELL; i++) newCfg[i] = CW'($urandom);
      loadNew();
      idle(200);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R10 actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule